// File: doc/BRIEF.md
# Event Timer Register Block

This block is the memory-mapped top level of a multi-channel event timer. It holds a 64-bit main counter, a global configuration register, a capability word, an interrupt status register and, for each channel, a configuration word, a comparator and a hidden period register. It decodes single 32-bit reads and writes inside a 1 KB window. Each read returns its data one cycle after the request.

The main counter advances by one on every clock while the global enable is set. When the enable is cleared, the counter stops and keeps its value, and software may then reload either half. An armed channel raises an event when the counter equals its comparator. The event does two things: it sets the channel's status bit and pulses one of the interrupt lines for one cycle. In periodic mode, the comparator then advances by the stored period.

A legacy replacement bit forces channel 0 onto line 0 and channel 1 onto line 8. The same bit drives an output that tells the legacy interval timer and the real-time clock to stay quiet.

Top module: `evt_timer_regs`

## Requirements
- R1: A read of offset 0x000 returns 0x8086A201 with the default three channels. Bits 12:8 of that word hold the channel count minus one, bit 13 flags a 64-bit counter and bit 15 flags legacy routing. A read of offset 0x004 returns the tick period in femtoseconds, 0x00989680.
- R2: Only bits 1:0 of the global configuration at 0x010 can be written. Bit 0 is the global enable and bit 1 is legacy mode. A read of 0x014 returns zero.
- R3: While the global enable is 1, the counter increments on every clock. While it is 0, the counter holds its value.
- R4: A write to 0x0F0 replaces the counter's low half and a write to 0x0F4 replaces its high half. Counting resumes from the written value.
- R5: A read of 0x0F0 captures the counter's high half. A later read of 0x0F4 returns that captured half, even if the counter has carried into its high half since.
- R6: Comparators reset to all ones. When the global enable goes from 0 to 1, every channel whose comparator is not all ones is armed. A write to a comparator while the block is enabled also arms that channel.
- R7: Channel n's configuration sits at 0x100+0x20·n, its comparator low half at +0x8 and its high half at +0xC. A one-shot channel with enable bit 2 set fires when the counter equals the comparator. It then pulses its line high for exactly one cycle, in the cycle after the match, and disarms.
- R8: With periodic bit 3 set and set-value bit 6 clear, a comparator write loads the hidden period. With bit 6 set, the write loads the comparator itself, and bit 6 then clears. After each periodic event, the comparator grows by the period.
- R9: Configuration bits 13:9 select the output line. In legacy mode, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Channel 2 keeps using its own route field.
- R10: The legacy_active output follows configuration bit 1 and is low after reset.
- R11: Status bit n at 0x020 is set by channel n's event. Writing a 1 to a status bit clears it.
- R12: Writes to 0x000 have no effect. Reads of unmapped offsets, and of channel slots past the last channel, return zero.
- R13: The channel configuration word keeps only the writable mask 0x3E4C and always reads bits 5 and 4 as 1. The word at +0x4 reads the route capability 0x00000C20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| irq_lines | output | NUM_LINES | Interrupt lines, one-cycle pulses |
| legacy_active | output | 1 | Legacy interval timer and RTC suppression |

## Verification
The bench builds the block with its defaults: three channels and 32 interrupt lines. This puts every channel slot in the window within reach, including the first slot past the last channel. Because the counter halves can be written directly, the bench can start the counter just below a 32-bit carry and show that the high-half capture stays coherent. It also places comparators a few ticks ahead of the counter, so one-shot, periodic and legacy-routed events each land at a cycle the bench can compute exactly.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned CFG_EN_BIT    = 2;
  localparam int unsigned CFG_PER_BIT   = 3;
  localparam int unsigned CFG_SETV_BIT  = 6;
  localparam int unsigned CFG_ROUTE_LSB = 9;
  localparam int unsigned ROUTE_W       = 5;
  localparam logic [31:0] ROUTE_CAP     = 32'h0000_0C20;
  localparam logic [31:0] TICK_FS       = 32'd10_000_000;

  localparam logic [9:0] A_CAP    = 10'h000;
  localparam logic [9:0] A_TICK   = 10'h004;
  localparam logic [9:0] A_GCFG   = 10'h010;
  localparam logic [9:0] A_STAT   = 10'h020;
  localparam logic [9:0] A_CNT_LO = 10'h0F0;
  localparam logic [9:0] A_CNT_HI = 10'h0F4;

  localparam logic [4:0] S_CFG    = 5'h00;
  localparam logic [4:0] S_CAP    = 5'h04;
  localparam logic [4:0] S_CMP_LO = 5'h08;
  localparam logic [4:0] S_CMP_HI = 5'h0C;

  typedef struct packed {
    logic [ROUTE_W-1:0] route;
    logic               setv;
    logic               per;
    logic               en;
  } ch_cfg_t;

  function automatic logic [31:0] cap_word(input int unsigned nch);
    logic [4:0] n;
    n = 5'(nch - 1);
    return {16'h8086, 1'b1, 1'b0, 1'b1, n, 8'h01};
  endfunction

  function automatic logic [31:0] cfg_word(input ch_cfg_t c);
    logic [31:0] w;
    w = 32'h0000_0030;
    w[CFG_EN_BIT]   = c.en;
    w[CFG_PER_BIT]  = c.per;
    w[CFG_SETV_BIT] = c.setv;
    w[CFG_ROUTE_LSB +: ROUTE_W] = c.route;
    return w;
  endfunction
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [31:0]        wdata,
  input  logic               cap_hi,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-33:0]  hi_held
);
  localparam int unsigned HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [HI_W-1:0]  hold_q, hold_nx;
  logic             cnt_ce, hold_ce;

  always_comb begin
    cnt_nx = cnt_q;
    if (run) cnt_nx = cnt_q + CNT_W'(1);
    if (wr_lo) cnt_nx[31:0] = wdata;
    if (wr_hi) cnt_nx[CNT_W-1:32] = HI_W'(wdata);
    cnt_ce  = run | wr_lo | wr_hi;
    hold_nx = cnt_q[CNT_W-1:32];
    hold_ce = cap_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      if (cnt_ce)  cnt_q  <= cnt_nx;
      if (hold_ce) hold_q <= hold_nx;
    end
  end

  assign cnt     = cnt_q;
  assign hi_held = hold_q;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gen_en,
  input  logic               gen_rise,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               cfg_wr,
  input  logic               cmp_lo_wr,
  input  logic               cmp_hi_wr,
  input  logic [31:0]        wdata,
  output logic [31:0]        cfg_rd,
  output logic [CNT_W-1:0]   cmp_rd,
  output logic [ROUTE_W-1:0] route,
  output logic               event_o
);
  localparam int unsigned HI_W = CNT_W - 32;

  ch_cfg_t          cfg_q, cfg_nx;
  logic [CNT_W-1:0] cmp_q, cmp_nx;
  logic [CNT_W-1:0] per_q, per_nx;
  logic             armed_q, armed_nx;
  logic             hit, to_cmp, cmp_wr, not_ones;

  always_comb begin
    hit      = armed_q & gen_en & (cnt == cmp_q);
    to_cmp   = ~cfg_q.per | cfg_q.setv;
    cmp_wr   = cmp_lo_wr | cmp_hi_wr;
    not_ones = ~(&cmp_q);

    cfg_nx = cfg_q;
    if (cfg_wr) begin
      cfg_nx.en    = wdata[CFG_EN_BIT];
      cfg_nx.per   = wdata[CFG_PER_BIT];
      cfg_nx.setv  = wdata[CFG_SETV_BIT];
      cfg_nx.route = wdata[CFG_ROUTE_LSB +: ROUTE_W];
    end
    if (cmp_wr) cfg_nx.setv = 1'b0;

    cmp_nx = cmp_q;
    per_nx = per_q;
    if (hit && cfg_q.per) cmp_nx = cmp_q + per_q;
    if (cmp_lo_wr) begin
      if (to_cmp) cmp_nx[31:0] = wdata;
      else        per_nx[31:0] = wdata;
    end
    if (cmp_hi_wr) begin
      if (to_cmp) cmp_nx[CNT_W-1:32] = HI_W'(wdata);
      else        per_nx[CNT_W-1:32] = HI_W'(wdata & 32'h7FFF_FFFF);
    end

    armed_nx = armed_q;
    if (gen_rise)               armed_nx = not_ones;
    else if (!gen_en)           armed_nx = 1'b0;
    else if (cmp_wr)            armed_nx = 1'b1;
    else if (hit && !cfg_q.per) armed_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cfg_wr | cmp_wr)          cfg_q <= cfg_nx;
      if (cmp_wr | (hit & cfg_q.per)) cmp_q <= cmp_nx;
      if (cmp_wr)                   per_q <= per_nx;
      armed_q <= armed_nx;
    end
  end

  assign cfg_rd  = cfg_word(cfg_q);
  assign cmp_rd  = cmp_q;
  assign route   = cfg_q.route;
  assign event_o = hit & cfg_q.en;
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             legacy,
  input  logic [NUM_CH-1:0]                ev,
  input  logic [NUM_CH-1:0][ROUTE_W-1:0]   route,
  output logic [NUM_LINES-1:0]             irq_lines
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] irq_q, irq_nx;
  logic [NUM_CH-1:0][LINE_W-1:0] sel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    if (i == 0) begin : g_l0
      assign sel[i] = legacy ? LINE_W'(0) : LINE_W'(route[i]);
    end else if (i == 1) begin : g_l1
      assign sel[i] = legacy ? LINE_W'(8) : LINE_W'(route[i]);
    end else begin : g_rt
      assign sel[i] = LINE_W'(route[i]);
    end
  end

  always_comb begin
    irq_nx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ev[i]) irq_nx[sel[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_nx;
  end

  assign irq_lines = irq_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [9:0]           req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 legacy_active
);
  localparam int unsigned CNT_W = 64;
  localparam logic [31:0] CAP_LO = cap_word(NUM_CH);

  logic rst_s;
  logic wr, rd;
  logic is_ch;
  logic [9:0] ch_off;
  logic [4:0] ch_idx, slot;

  logic [1:0]        gcfg_q, gcfg_nx;
  logic [NUM_CH-1:0] stat_q, stat_nx;
  logic [31:0]       rdat_q, rdat_nx;
  logic              rval_q;
  logic              gcfg_wr, stat_wr, gen_rise;
  logic              cnt_lo_wr, cnt_hi_wr, cnt_any_wr, cnt_lo_rd;

  logic [CNT_W-1:0]  cnt;
  logic [31:0]       cnt_hi_held;

  logic [NUM_CH-1:0]               cfg_wr, cmp_lo_wr, cmp_hi_wr, ev;
  logic [NUM_CH-1:0][31:0]         cfg_rd;
  logic [NUM_CH-1:0][CNT_W-1:0]    cmp_rd;
  logic [NUM_CH-1:0][ROUTE_W-1:0]  route;

  evt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  always_comb begin
    wr         = req_valid & req_write;
    rd         = req_valid & ~req_write;
    is_ch      = req_addr[9:8] != 2'b00;
    ch_off     = req_addr - 10'h100;
    ch_idx     = ch_off[9:5];
    slot       = ch_off[4:0];
    gcfg_wr    = wr & (req_addr == A_GCFG);
    stat_wr    = wr & (req_addr == A_STAT);
    cnt_lo_wr  = wr & (req_addr == A_CNT_LO);
    cnt_hi_wr  = wr & (req_addr == A_CNT_HI);
    cnt_any_wr = cnt_lo_wr | cnt_hi_wr;
    cnt_lo_rd  = rd & (req_addr == A_CNT_LO);
    gen_rise   = gcfg_wr & req_wdata[0] & ~gcfg_q[0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign cfg_wr[i]    = wr & is_ch & (ch_idx == 5'(i)) & (slot == S_CFG);
    assign cmp_lo_wr[i] = wr & is_ch & (ch_idx == 5'(i)) & (slot == S_CMP_LO);
    assign cmp_hi_wr[i] = wr & is_ch & (ch_idx == 5'(i)) & (slot == S_CMP_HI);

    evt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_s),
      .gen_en(gcfg_q[0]), .gen_rise(gen_rise), .cnt(cnt),
      .cfg_wr(cfg_wr[i]), .cmp_lo_wr(cmp_lo_wr[i]), .cmp_hi_wr(cmp_hi_wr[i]),
      .wdata(req_wdata),
      .cfg_rd(cfg_rd[i]), .cmp_rd(cmp_rd[i]), .route(route[i]), .event_o(ev[i])
    );
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run(gcfg_q[0]),
    .wr_lo(cnt_lo_wr), .wr_hi(cnt_hi_wr), .wdata(req_wdata),
    .cap_hi(cnt_lo_rd), .cnt(cnt), .hi_held(cnt_hi_held)
  );

  evt_irq_router #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_rt (
    .clk(clk), .rst_n(rst_s), .legacy(gcfg_q[1]),
    .ev(ev), .route(route), .irq_lines(irq_lines)
  );

  always_comb begin
    gcfg_nx = gcfg_wr ? req_wdata[1:0] : gcfg_q;
    stat_nx = stat_q;
    if (stat_wr) stat_nx = stat_q & ~req_wdata[NUM_CH-1:0];
    stat_nx = stat_nx | ev;

    rdat_nx = '0;
    if (is_ch) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == 5'(i)) begin
          case (slot)
            S_CFG:    rdat_nx = cfg_rd[i];
            S_CAP:    rdat_nx = ROUTE_CAP;
            S_CMP_LO: rdat_nx = cmp_rd[i][31:0];
            S_CMP_HI: rdat_nx = cmp_rd[i][CNT_W-1:32];
            default:  rdat_nx = '0;
          endcase
        end
      end
    end else begin
      case (req_addr)
        A_CAP:    rdat_nx = CAP_LO;
        A_TICK:   rdat_nx = TICK_FS;
        A_GCFG:   rdat_nx = {30'd0, gcfg_q};
        A_STAT:   rdat_nx = 32'(stat_q);
        A_CNT_LO: rdat_nx = cnt[31:0];
        A_CNT_HI: rdat_nx = cnt_hi_held;
        default:  rdat_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      gcfg_q <= '0;
      stat_q <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      if (gcfg_wr) gcfg_q <= gcfg_nx;
      stat_q <= stat_nx;
      rval_q <= rd;
      if (rd) rdat_q <= rdat_nx;
    end
  end

  assign rd_valid      = rval_q;
  assign rd_data       = rdat_q;
  assign legacy_active = gcfg_q[1];
endmodule

// File: rtl/evt_timer_sva.sv
module evt_timer_sva
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [9:0]           req_addr,
  input logic [31:0]          req_wdata,
  input logic                 rd_valid,
  input logic [31:0]          rd_data,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 legacy_active,
  input logic [NUM_CH-1:0]    status,
  input logic [63:0]          cnt,
  input logic                 gen_en,
  input logic                 cnt_wr
);
  p_cap_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == A_CAP) |=> (rd_valid && rd_data == cap_word(NUM_CH)));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !cnt_wr) |=> $stable(cnt));

  p_legacy_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy_active) |-> $past(req_valid && req_write && req_addr == A_GCFG && req_wdata[1]));

  p_irq_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_lines) |-> (status != '0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 10'h00C) |=> (rd_valid && rd_data == 32'd0));
endmodule

bind evt_timer_regs evt_timer_sva #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_sva (
  .clk(clk), .rst_n(rst_s), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
  .irq_lines(irq_lines), .legacy_active(legacy_active), .status(stat_q),
  .cnt(cnt), .gen_en(gcfg_q[0]), .cnt_wr(cnt_any_wr)
);

// File: tb/evt_timer_regs_tb.sv
module evt_timer_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] irq_lines;
  logic        legacy_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb[$];

  int first_k[32];
  int hits[32];
  int t7[$];

  always #5 clk = ~clk;

  evt_timer_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_lines(irq_lines), .legacy_active(legacy_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected read actual=%h expected=none", rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, rd_data & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb.push_back(it);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic watch(input int n);
    for (int l = 0; l < 32; l++) begin first_k[l] = 0; hits[l] = 0; end
    t7.delete();
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      for (int l = 0; l < 32; l++) begin
        if (irq_lines[l]) begin
          hits[l]++;
          if (first_k[l] == 0) first_k[l] = k;
          if (l == 7) t7.push_back(k);
        end
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R10 reset legacy_active", 32'(legacy_active), 32'd0);
    chk("R7 reset irq_lines", irq_lines, 32'd0);

    rd(10'h000, 32'h8086A201, '1, "R1 capability");
    rd(10'h004, 32'h00989680, '1, "R1 tick period");

    wr(10'h000, 32'hDEADBEEF);
    rd(10'h000, 32'h8086A201, '1, "R12 capability write ignored");
    rd(10'h008, 32'h0, '1, "R12 unmapped 0x008");
    rd(10'h160, 32'h0, '1, "R12 channel slot past last");
    rd(10'h3FC, 32'h0, '1, "R12 top of window");

    wr(10'h010, 32'hFFFFFFFE);
    rd(10'h010, 32'h2, '1, "R2 only bits 1:0 writable");
    rd(10'h014, 32'h0, '1, "R2 config high word");
    chk("R10 legacy_active set", 32'(legacy_active), 32'd1);
    wr(10'h010, 32'h0);
    chk("R10 legacy_active cleared", 32'(legacy_active), 32'd0);

    rd(10'h100, 32'h30, '1, "R13 channel config reset");
    rd(10'h104, 32'h00000C20, '1, "R13 route capability");
    wr(10'h100, 32'hFFFFFFFF);
    rd(10'h100, 32'h3E7C, '1, "R13 config writable mask");
    wr(10'h100, 32'h0);
    rd(10'h108, 32'hFFFFFFFF, '1, "R6 comparator reset low");
    rd(10'h12C, 32'hFFFFFFFF, '1, "R6 comparator reset high");

    wr(10'h0F0, 32'h11111111);
    wr(10'h0F4, 32'h00000022);
    rd(10'h0F0, 32'h11111111, '1, "R4 counter low write");
    rd(10'h0F4, 32'h00000022, '1, "R4 counter high write");

    wr(10'h0F0, 32'h100);
    wr(10'h0F4, 32'h0);
    wr(10'h010, 32'h1);
    repeat (9) @(negedge clk);
    wr(10'h010, 32'h0);
    rd(10'h0F0, 32'h10A, '1, "R3 counter ran ten ticks");
    repeat (5) @(negedge clk);
    rd(10'h0F0, 32'h10A, '1, "R3 counter holds when disabled");
    rd(10'h0F4, 32'h0, '1, "R3 counter high");
    rd(10'h020, 32'h0, '1, "R6 all-ones comparators never armed");

    wr(10'h0F0, 32'hFFFFFFF0);
    wr(10'h0F4, 32'h5);
    wr(10'h010, 32'h1);
    rd(10'h0F0, 32'h0, 32'h0, "R5 low read (value free)");
    repeat (40) @(negedge clk);
    rd(10'h0F4, 32'h5, '1, "R5 high half held across carry");
    wr(10'h010, 32'h0);
    rd(10'h0F0, 32'h0, 32'h0, "R5 low read again");
    rd(10'h0F4, 32'h6, '1, "R5 high half after carry");

    wr(10'h0F0, 32'h1000);
    wr(10'h0F4, 32'h0);
    wr(10'h100, 32'h604);
    wr(10'h108, 32'h1008);
    wr(10'h10C, 32'h0);
    wr(10'h010, 32'h1);
    watch(40);
    wr(10'h010, 32'h0);
    chk("R7 one-shot first pulse cycle", 32'(first_k[3]), 32'd9);
    chk("R7 one-shot single pulse", 32'(hits[3]), 32'd1);
    rd(10'h020, 32'h1, '1, "R11 status set by channel 0");
    wr(10'h020, 32'h1);
    rd(10'h020, 32'h0, '1, "R11 write one clears");

    wr(10'h0F0, 32'h2000);
    wr(10'h140, 32'hE4C);
    wr(10'h14C, 32'h0);
    wr(10'h140, 32'hE4C);
    wr(10'h148, 32'h2004);
    wr(10'h148, 32'd10);
    rd(10'h148, 32'h2004, '1, "R8 period write leaves comparator");
    rd(10'h140, 32'hE3C, '1, "R8 set-value bit self-clears");
    wr(10'h010, 32'h1);
    watch(40);
    wr(10'h010, 32'h0);
    chk("R8 periodic event count", 32'(t7.size()), 32'd4);
    if (t7.size() == 4) begin
      chk("R8 first periodic event", 32'(t7[0]), 32'd5);
      chk("R8 period spacing", 32'(t7[3] - t7[0]), 32'd30);
    end
    rd(10'h148, 32'h202C, '1, "R8 comparator advanced by period");
    wr(10'h020, 32'h7);

    wr(10'h0F0, 32'h3000);
    wr(10'h108, 32'h3004);
    wr(10'h120, 32'h804);
    wr(10'h128, 32'h3006);
    wr(10'h12C, 32'h0);
    wr(10'h140, 32'hE4C);
    wr(10'h148, 32'h3008);
    wr(10'h010, 32'h3);
    chk("R10 legacy_active with enable", 32'(legacy_active), 32'd1);
    watch(12);
    wr(10'h010, 32'h0);
    chk("R9 legacy channel 0 on line 0", 32'(first_k[0]), 32'd5);
    chk("R9 legacy channel 1 on line 8", 32'(first_k[8]), 32'd7);
    chk("R9 channel 2 keeps route 7", 32'(first_k[7]), 32'd9);
    chk("R9 route fields overridden", 32'(hits[3] + hits[4]), 32'd0);
    chk("R10 legacy_active released", 32'(legacy_active), 32'd0);
    rd(10'h020, 32'h7, '1, "R11 all three status bits");
    wr(10'h020, 32'h5);
    rd(10'h020, 32'h2, '1, "R11 partial clear");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule